// File: doc/BRIEF.md
# Edge-Triggered Debug Sample Capture

This block freezes a single snapshot of receive-path observation values into two readback words, so that a register interface can read them at leisure. Software writes a trigger bit. On the clock edge at which that bit is seen going from 0 to 1, the block loads both words at once. The data comes from a source picked by a 2-bit selector and, for the ADC source, by a tap bit.

The sources are:
- a received-signal-strength value;
- I/Q ADC samples, taken either at the input or at the output of the receive processing chain;
- I and Q self-test signatures, each paired with a self-test state field.

Between triggers the words hold their value, whatever the inputs do. The register decoding and the logic that produces the observed values are outside this block.

Top module: `dbg_sample_capture`

## Requirements
- R1: While rst_ni is low, word0_o and word1_o are zero and the stored trigger history is cleared; they are still zero at the first clock edge after reset is released.
- R2: A capture happens only at a rising clock edge where cap_trig_i is 1 and was 0 at the previous rising edge. Holding cap_trig_i at 1 or at 0 leaves both words unchanged.
- R3: Selector code 2'b00 (the reset default source) captures the strength value. word1_o takes bits [WORD_W-1:0], and word0_o takes the remaining upper bits, zero-extended.
- R4: Selector 2'b01 with adc_tap_i = 0 captures the chain-input ADC samples: word0_o is I and word1_o is Q, each sign-extended to WORD_W.
- R5: Selector 2'b01 with adc_tap_i = 1 captures the chain-output ADC samples, with the same word placement and sign extension as R4.
- R6: Selector 2'b10 captures the I signature into word0_o and the self-test state, zero-extended, into word1_o.
- R7: Selector 2'b11 captures the Q signature into word0_o and the self-test state, zero-extended, into word1_o.
- R8: The selector, the tap bit and the data are sampled only at the capture edge. Changing them at any other time does not alter the words, and adc_tap_i has no effect for selector codes other than 2'b01.
- R9: New words appear right after the clock edge that detects the transition. Before that edge the previous words remain visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_trig_i | input | 1 | Software capture bit; a 0-to-1 transition triggers a capture |
| cap_sel_i | input | 2 | Source selector |
| adc_tap_i | input | 1 | ADC tap: 0 chain input, 1 chain output |
| rssi_i | input | RSSI_W | Signal strength value |
| adc_in_i_i | input | ADC_W | Chain-input ADC I sample |
| adc_in_q_i | input | ADC_W | Chain-input ADC Q sample |
| adc_out_i_i | input | ADC_W | Chain-output ADC I sample |
| adc_out_q_i | input | ADC_W | Chain-output ADC Q sample |
| bist_sig_i_i | input | BSIG_W | Self-test signature, I channel |
| bist_sig_q_i | input | BSIG_W | Self-test signature, Q channel |
| bist_state_i | input | BSTATE_W | Self-test state field |
| word0_o | output | WORD_W | First readback word |
| word1_o | output | WORD_W | Second readback word |

## Verification
The bench builds the block with its default parameters: an 18-bit strength value, 12-bit ADC samples, 16-bit signatures, a 3-bit state field and 16-bit words. Because the strength value is wider than a word, these defaults exercise the split across both words. Because the ADC samples are narrower than a word, they exercise sign extension of both positive and negative samples, including the extreme values 0x7FF and 0x800. The 3-bit state field exercises zero extension into the second word.

// File: rtl/dbg_cap_pkg.sv
package dbg_cap_pkg;
  typedef enum logic [1:0] {
    SEL_RSSI   = 2'b00,
    SEL_ADC    = 2'b01,
    SEL_BSIG_I = 2'b10,
    SEL_BSIG_Q = 2'b11
  } cap_sel_e;

  localparam int unsigned NUM_WORDS = 2;
endpackage

// File: rtl/dbg_cap_edge.sv
module dbg_cap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/dbg_cap_mux.sv
module dbg_cap_mux #(
  parameter int unsigned RSSI_W   = 18,
  parameter int unsigned ADC_W    = 12,
  parameter int unsigned BSIG_W   = 16,
  parameter int unsigned BSTATE_W = 3,
  parameter int unsigned WORD_W   = 16
) (
  input  logic [1:0]          sel_i,
  input  logic                tap_i,
  input  logic [RSSI_W-1:0]   rssi_i,
  input  logic [ADC_W-1:0]    ain_i_i,
  input  logic [ADC_W-1:0]    ain_q_i,
  input  logic [ADC_W-1:0]    aout_i_i,
  input  logic [ADC_W-1:0]    aout_q_i,
  input  logic [BSIG_W-1:0]   sig_i_i,
  input  logic [BSIG_W-1:0]   sig_q_i,
  input  logic [BSTATE_W-1:0] state_i,
  output logic [dbg_cap_pkg::NUM_WORDS-1:0][WORD_W-1:0] words_o
);
  import dbg_cap_pkg::*;

  logic [WORD_W-1:0] rssi_hi, rssi_lo;
  logic [ADC_W-1:0]  adc_i, adc_q;
  logic [WORD_W-1:0] adc_i_x, adc_q_x, state_x;

  // strength split: low bits to word1, remainder to word0
  if (RSSI_W > WORD_W) begin : g_rssi_split
    assign rssi_hi = WORD_W'(rssi_i[RSSI_W-1:WORD_W]);
    assign rssi_lo = rssi_i[WORD_W-1:0];
  end else begin : g_rssi_fit
    assign rssi_hi = '0;
    assign rssi_lo = WORD_W'(rssi_i);
  end

  assign adc_i   = tap_i ? aout_i_i : ain_i_i;
  assign adc_q   = tap_i ? aout_q_i : ain_q_i;
  assign adc_i_x = WORD_W'($signed(adc_i));
  assign adc_q_x = WORD_W'($signed(adc_q));
  assign state_x = WORD_W'(state_i);

  always_comb begin
    unique case (cap_sel_e'(sel_i))
      SEL_RSSI:   words_o = {rssi_lo, rssi_hi};
      SEL_ADC:    words_o = {adc_q_x, adc_i_x};
      SEL_BSIG_I: words_o = {state_x, WORD_W'(sig_i_i)};
      SEL_BSIG_Q: words_o = {state_x, WORD_W'(sig_q_i)};
      default:    words_o = '0;
    endcase
  end
endmodule

// File: rtl/dbg_cap_hold.sv
module dbg_cap_hold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic [dbg_cap_pkg::NUM_WORDS-1:0][WORD_W-1:0] d_i,
  output logic [dbg_cap_pkg::NUM_WORDS-1:0][WORD_W-1:0] q_o
);
  for (genvar w = 0; w < dbg_cap_pkg::NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[w] <= '0;
      else if (load_i) q_o[w] <= d_i[w];
    end
  end
endmodule

// File: rtl/dbg_sample_capture.sv
module dbg_sample_capture #(
  parameter int unsigned RSSI_W   = 18,
  parameter int unsigned ADC_W    = 12,
  parameter int unsigned BSIG_W   = 16,
  parameter int unsigned BSTATE_W = 3,
  parameter int unsigned WORD_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_trig_i,
  input  logic [1:0]          cap_sel_i,
  input  logic                adc_tap_i,
  input  logic [RSSI_W-1:0]   rssi_i,
  input  logic [ADC_W-1:0]    adc_in_i_i,
  input  logic [ADC_W-1:0]    adc_in_q_i,
  input  logic [ADC_W-1:0]    adc_out_i_i,
  input  logic [ADC_W-1:0]    adc_out_q_i,
  input  logic [BSIG_W-1:0]   bist_sig_i_i,
  input  logic [BSIG_W-1:0]   bist_sig_q_i,
  input  logic [BSTATE_W-1:0] bist_state_i,
  output logic [WORD_W-1:0]   word0_o,
  output logic [WORD_W-1:0]   word1_o
);
  logic cap_rise;
  logic [dbg_cap_pkg::NUM_WORDS-1:0][WORD_W-1:0] sel_words, held_words;

  dbg_cap_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (cap_trig_i),
    .rise_o (cap_rise)
  );

  dbg_cap_mux #(
    .RSSI_W(RSSI_W), .ADC_W(ADC_W), .BSIG_W(BSIG_W),
    .BSTATE_W(BSTATE_W), .WORD_W(WORD_W)
  ) u_mux (
    .sel_i    (cap_sel_i),
    .tap_i    (adc_tap_i),
    .rssi_i   (rssi_i),
    .ain_i_i  (adc_in_i_i),
    .ain_q_i  (adc_in_q_i),
    .aout_i_i (adc_out_i_i),
    .aout_q_i (adc_out_q_i),
    .sig_i_i  (bist_sig_i_i),
    .sig_q_i  (bist_sig_q_i),
    .state_i  (bist_state_i),
    .words_o  (sel_words)
  );

  dbg_cap_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cap_rise),
    .d_i    (sel_words),
    .q_o    (held_words)
  );

  assign word0_o = held_words[0];
  assign word1_o = held_words[1];
endmodule

// File: rtl/dbg_sample_capture_chk.sv
module dbg_sample_capture_chk #(
  parameter int unsigned RSSI_W   = 18,
  parameter int unsigned ADC_W    = 12,
  parameter int unsigned BSIG_W   = 16,
  parameter int unsigned BSTATE_W = 3,
  parameter int unsigned WORD_W   = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cap_trig_i,
  input logic [1:0]          cap_sel_i,
  input logic                adc_tap_i,
  input logic [RSSI_W-1:0]   rssi_i,
  input logic [ADC_W-1:0]    adc_in_i_i,
  input logic [ADC_W-1:0]    adc_in_q_i,
  input logic [ADC_W-1:0]    adc_out_i_i,
  input logic [ADC_W-1:0]    adc_out_q_i,
  input logic [BSIG_W-1:0]   bist_sig_i_i,
  input logic [BSIG_W-1:0]   bist_sig_q_i,
  input logic [BSTATE_W-1:0] bist_state_i,
  input logic [WORD_W-1:0]   word0_o,
  input logic [WORD_W-1:0]   word1_o
);
  logic trig_seen;
  logic fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_seen <= 1'b0;
    else         trig_seen <= cap_trig_i;
  end
  assign fire = cap_trig_i && !trig_seen;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (word0_o == '0 && word1_o == '0));

  // R2
  no_fire_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> ($stable(word0_o) && $stable(word1_o)));

  // R3
  rssi_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cap_sel_i == 2'b00) |=> word1_o == $past(rssi_i[WORD_W-1:0]));

  // R4
  adc_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cap_sel_i == 2'b01 && !adc_tap_i) |=>
      (word0_o == WORD_W'($signed($past(adc_in_i_i))) &&
       word1_o == WORD_W'($signed($past(adc_in_q_i)))));

  // R5
  adc_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cap_sel_i == 2'b01 && adc_tap_i) |=>
      (word0_o == WORD_W'($signed($past(adc_out_i_i))) &&
       word1_o == WORD_W'($signed($past(adc_out_q_i)))));

  // R6
  bist_i_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cap_sel_i == 2'b10) |=>
      (word0_o == WORD_W'($past(bist_sig_i_i)) &&
       word1_o == WORD_W'($past(bist_state_i))));

  // R7
  bist_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cap_sel_i == 2'b11) |=>
      (word0_o == WORD_W'($past(bist_sig_q_i)) &&
       word1_o == WORD_W'($past(bist_state_i))));
endmodule

bind dbg_sample_capture dbg_sample_capture_chk #(
  .RSSI_W(RSSI_W), .ADC_W(ADC_W), .BSIG_W(BSIG_W),
  .BSTATE_W(BSTATE_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cap_trig_i   (cap_trig_i),
  .cap_sel_i    (cap_sel_i),
  .adc_tap_i    (adc_tap_i),
  .rssi_i       (rssi_i),
  .adc_in_i_i   (adc_in_i_i),
  .adc_in_q_i   (adc_in_q_i),
  .adc_out_i_i  (adc_out_i_i),
  .adc_out_q_i  (adc_out_q_i),
  .bist_sig_i_i (bist_sig_i_i),
  .bist_sig_q_i (bist_sig_q_i),
  .bist_state_i (bist_state_i),
  .word0_o      (word0_o),
  .word1_o      (word1_o)
);

// File: tb/tb_dbg_sample_capture.sv
module tb_dbg_sample_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        tap = 1'b0;
  logic [17:0] rssi = 18'h2A5C3;
  logic [11:0] ain_i = 12'h123, ain_q = 12'hF80;
  logic [11:0] aout_i = 12'h7FF, aout_q = 12'h800;
  logic [15:0] sig_i = 16'hBEEF, sig_q = 16'h1234;
  logic [2:0]  state = 3'h5;
  logic [15:0] w0, w1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_sample_capture dut (
    .clk_i(clk), .rst_ni(rst_n), .cap_trig_i(trig), .cap_sel_i(sel),
    .adc_tap_i(tap), .rssi_i(rssi), .adc_in_i_i(ain_i), .adc_in_q_i(ain_q),
    .adc_out_i_i(aout_i), .adc_out_q_i(aout_q), .bist_sig_i_i(sig_i),
    .bist_sig_q_i(sig_q), .bist_state_i(state), .word0_o(w0), .word1_o(w1)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        tap;
    logic [15:0] exp0;
    logic [15:0] exp1;
    logic [7:0]  req;
  } vec_t;

  // expected words derived by hand from R3..R8 for the fixed input data
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 16'h0002, 16'hA5C3, 8'd3},
    '{2'b01, 1'b0, 16'h0123, 16'hFF80, 8'd4},
    '{2'b01, 1'b1, 16'h07FF, 16'hF800, 8'd5},
    '{2'b10, 1'b0, 16'hBEEF, 16'h0005, 8'd6},
    '{2'b11, 1'b1, 16'h1234, 16'h0005, 8'd7},
    '{2'b00, 1'b1, 16'h0002, 16'hA5C3, 8'd8},
    '{2'b10, 1'b1, 16'hBEEF, 16'h0005, 8'd8}
  };

  task automatic chk(string req, logic [15:0] act0, logic [15:0] act1,
                     logic [15:0] e0, logic [15:0] e1);
    checks++;
    if (act0 !== e0 || act1 !== e1) begin
      errors++;
      $display("FAIL %s: actual %h/%h expected %h/%h", req, act0, act1, e0, e1);
    end
  endtask

  task automatic pulse();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", w0, w1, 16'h0, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", w0, w1, 16'h0, 16'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel = VECS[i].sel; tap = VECS[i].tap; trig = 1'b1;
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), w0, w1, VECS[i].exp0, VECS[i].exp1);
      trig = 1'b0;
    end

    // R2: held high, data changes, no recapture
    sel = 2'b00; pulse();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) rssi = 18'h1_0001;
    repeat (3) @(negedge clk);
    chk("R2 level high", w0, w1, 16'h0002, 16'hA5C3);
    // R2: held low, data changes, no capture
    trig = 1'b0; sel = 2'b01; ain_i = 12'h001;
    repeat (3) @(negedge clk);
    chk("R2 level low", w0, w1, 16'h0002, 16'hA5C3);

    // R9: before the detecting edge, old words still visible
    sel = 2'b00;
    @(negedge clk) trig = 1'b1;
    #1 chk("R9 before edge", w0, w1, 16'h0002, 16'hA5C3);
    @(negedge clk);
    chk("R9 after edge", w0, w1, 16'h0001, 16'h0001);
    trig = 1'b0;

    // R8: selector and data move between triggers, words hold
    sel = 2'b11; sig_q = 16'hCAFE; rssi = 18'h3FFFF;
    repeat (2) @(negedge clk);
    chk("R8 between triggers", w0, w1, 16'h0001, 16'h0001);
    pulse();
    chk("R7 new signature", w0, w1, 16'hCAFE, 16'h0005);

    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1 chk("R1 async reset", w0, w1, 16'h0, 16'h0);
    @(negedge clk) rst_n = 1'b1;
    // R1: trigger history cleared, first rise after reset captures
    sel = 2'b00; pulse();
    chk("R1 R3 post-reset capture", w0, w1, 16'h0003, 16'hFFFF);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule